// File: doc/BRIEF.md
# Packed Signed Saturating Add/Subtract Unit

This unit adds or subtracts two 32-bit operands with signed saturation. Each operation runs in one of three lane layouts: a single full-width lane, two half-width lanes or four byte lanes. Each lane works on its own bits and never receives a carry from its neighbour. A lane result that falls outside the lane's signed range is clamped to the nearest limit. The unit registers the packed result, and it is visible one clock after the request.

The unit also keeps a sticky saturation flag. Only full-width operations that clamp can set this flag. Packed operations leave it alone, even when one of their lanes clamps. Arithmetic never clears the flag. It drops to zero only through a dedicated clear input. A per-lane clamp status vector is registered with every result, so that lane clamping can be observed in any layout.

Top module: `packed_sat_unit`

## Requirements
- R1: With `inOp[1:0]`=0 (full width) and `inOp[2]`=0, `result` is opA+opB as signed 32-bit values, clamped to the range -2^31 to 2^31-1.
- R2: With `inOp[2]`=1 (subtract), every lane of `result` is the lane of opA minus the matching lane of opB, clamped to that lane's signed range.
- R3: With `inOp[1:0]`=1 (two 16-bit lanes), bits [16k+15:16k] of `result` depend only on the same bits of the operands and are clamped to -32768 to 32767.
- R4: With `inOp[1:0]`=2 or 3 (four 8-bit lanes), bits [8k+7:8k] of `result` depend only on the same bits of the operands and are clamped to -128 to 127. No carry crosses a lane boundary.
- R5: `result`, `laneSat` and `outValid` change in the first clock edge after `inValid` is sampled high. `outValid` is high for exactly the cycles that follow an accepted request.
- R6: While `inValid` is low, `result` and `laneSat` keep their previous values, whatever the operands do.
- R7: A full-width request whose exact result differs from its clamped result sets `qFlag` to 1 at the next clock edge.
- R8: `qFlag` stays 1 through later requests that do not clamp. Arithmetic never clears it.
- R9: Half-width and byte-lane requests never change `qFlag`, even when lanes clamp.
- R10: `qClear` high forces `qFlag` to 0 at the next edge. It has priority over a set in the same cycle.
- R11: `laneSat[k]` is 1 when lane k clamped. In full-width mode only bit 0 can be set. In half-width mode only bits 0 and 1 can be set. Bit k belongs to the lane at the lowest bit positions plus k.
- R12: After reset, `outValid`, `result`, `laneSat` and `qFlag` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| inOp | input | 3 | Bit 2: subtract; bits 1:0: lane layout (0 word, 1 halves, 2/3 bytes) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| qClear | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Result valid, one cycle after a request |
| result | output | 32 | Clamped packed result |
| laneSat | output | 4 | Per-lane clamp status of the last result |
| qFlag | output | 1 | Sticky full-width saturation flag |

## Verification
The bench builds the unit with its default width of 32 bits. At that width the lanes are 32, 16 and 8 bits, which are the widths the requirements name. This lets a wide-integer reference model in the bench compute the exact sum or difference of each lane and its clamp. Directed operands hit both ends of every lane range. They also put a saturating lane next to a lane that does not saturate, and they present a clear in the same cycle as a full-width overflow.

// File: rtl/satq_pkg.sv
package satq_pkg;
  typedef enum logic [1:0] {
    MODE_WORD     = 2'd0,
    MODE_HALF     = 2'd1,
    MODE_BYTE     = 2'd2,
    MODE_BYTE_ALT = 2'd3
  } laneMode_e;

  typedef struct packed {
    logic      load;
    logic      isSub;
    laneMode_e mode;
  } dpStrobe_t;

  localparam int MAX_LANES = 4;
endpackage

// File: rtl/satq_lane.sv
module satq_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isSub,
  output logic [W-1:0] sum,
  output logic         sat
);
  logic [W:0] wide;
  always_comb begin
    wide = isSub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});
    sat  = wide[W] ^ wide[W-1];
    if (sat)
      sum = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      sum = wide[W-1:0];
  end
endmodule

// File: rtl/satq_datapath.sv
module satq_datapath
  import satq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic                 wordSat,
  output logic [DATA_W-1:0]    result,
  output logic [MAX_LANES-1:0] laneSat
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int BYTE_W  = DATA_W / MAX_LANES;
  localparam int N_HALF  = 2;

  logic [DATA_W-1:0]    wordSum, halfSum, byteSum;
  logic [N_HALF-1:0]    halfSat;
  logic [MAX_LANES-1:0] byteSat;
  logic [DATA_W-1:0]    nextResult;
  logic [MAX_LANES-1:0] nextSat;

  satq_lane #(.W(DATA_W)) uWord (
    .a(opA), .b(opB), .isSub(strobe.isSub), .sum(wordSum), .sat(wordSat)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : gHalf
    satq_lane #(.W(HALF_W)) uLane (
      .a(opA[h*HALF_W +: HALF_W]), .b(opB[h*HALF_W +: HALF_W]),
      .isSub(strobe.isSub), .sum(halfSum[h*HALF_W +: HALF_W]), .sat(halfSat[h])
    );
  end

  for (genvar k = 0; k < MAX_LANES; k++) begin : gByte
    satq_lane #(.W(BYTE_W)) uLane (
      .a(opA[k*BYTE_W +: BYTE_W]), .b(opB[k*BYTE_W +: BYTE_W]),
      .isSub(strobe.isSub), .sum(byteSum[k*BYTE_W +: BYTE_W]), .sat(byteSat[k])
    );
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_WORD: begin
        nextResult = wordSum;
        nextSat    = {{(MAX_LANES-1){1'b0}}, wordSat};
      end
      MODE_HALF: begin
        nextResult = halfSum;
        nextSat    = {{(MAX_LANES-N_HALF){1'b0}}, halfSat};
      end
      default: begin
        nextResult = byteSum;
        nextSat    = byteSat;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      laneSat <= '0;
    end else if (strobe.load) begin
      result  <= nextResult;
      laneSat <= nextSat;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(result) && $stable(laneSat)));

  assert_word_lane_map_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.mode == MODE_WORD) |=> (laneSat[MAX_LANES-1:1] == '0));

  assert_half_lane_map_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.mode == MODE_HALF) |=> (laneSat[MAX_LANES-1:N_HALF] == '0));
endmodule

// File: rtl/satq_ctrl.sv
module satq_ctrl
  import satq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [2:0] inOp,
  input  logic      qClear,
  input  logic      wordSat,
  output dpStrobe_t strobe,
  output logic      outValid,
  output logic      qFlag
);
  logic qSet;

  always_comb begin
    strobe.load  = inValid;
    strobe.isSub = inOp[2];
    strobe.mode  = laneMode_e'(inOp[1:0]);
    qSet = inValid && (strobe.mode == MODE_WORD) && wordSat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      qFlag    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (qClear)    qFlag <= 1'b0;
      else if (qSet) qFlag <= 1'b1;
    end
  end

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_q_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (qFlag && !qClear) |=> qFlag);

  assert_packed_keeps_q_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp[1:0] != 2'd0 && !qClear) |=> (qFlag == $past(qFlag)));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    qClear |=> !qFlag);

  assert_word_sets_q_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp[1:0] == 2'd0 && wordSat && !qClear) |=> qFlag);
endmodule

// File: rtl/packed_sat_unit.sv
module packed_sat_unit
  import satq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  inOp,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        qClear,
  output logic        outValid,
  output logic [31:0] result,
  output logic [3:0]  laneSat,
  output logic        qFlag
);
  dpStrobe_t strobe;
  logic      wordSat;

  satq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .qClear(qClear),
    .wordSat(wordSat), .strobe(strobe), .outValid(outValid), .qFlag(qFlag)
  );

  satq_datapath #(.DATA_W(32)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .wordSat(wordSat), .result(result), .laneSat(laneSat)
  );
endmodule

// File: tb/tb_packed_sat_unit.sv
module tb_packed_sat_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        qClear = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic [3:0]  laneSat;
  logic        qFlag;

  int testsRun = 0, testsFailed = 0;
  logic qModel = 1'b0;

  always #2 clk = ~clk;

  packed_sat_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .opA(opA), .opB(opB),
    .qClear(qClear), .outValid(outValid), .result(result), .laneSat(laneSat), .qFlag(qFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refCalc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic [3:0] s, output logic ws);
    int w;
    int n;
    w = (op[1:0] == 2'd0) ? 32 : (op[1:0] == 2'd1) ? 16 : 8;
    n = 32 / w;
    r = '0; s = '0; ws = 1'b0;
    for (int i = 0; i < n; i++) begin
      longint mask, va, vb, ex, mx, mn, cl;
      mask = (longint'(1) <<< w) - 1;
      va = longint'({32'd0, a}) >>> (i*w) & mask;
      vb = longint'({32'd0, b}) >>> (i*w) & mask;
      if (va >= (longint'(1) <<< (w-1))) va -= (longint'(1) <<< w);
      if (vb >= (longint'(1) <<< (w-1))) vb -= (longint'(1) <<< w);
      mx = (longint'(1) <<< (w-1)) - 1;
      mn = -(longint'(1) <<< (w-1));
      ex = op[2] ? va - vb : va + vb;
      cl = (ex > mx) ? mx : (ex < mn) ? mn : ex;
      r |= 32'((cl & mask) <<< (i*w));
      s[i] = (cl != ex);
    end
    ws = (op[1:0] == 2'd0) && s[0];
  endfunction

  task automatic runOp(input string tag, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic clr);
    logic [31:0] r; logic [3:0] s; logic ws;
    refCalc(op, a, b, r, s, ws);
    @(negedge clk);
    inValid = 1'b1; inOp = op; opA = a; opB = b; qClear = clr;
    @(posedge clk); #1;
    inValid = 1'b0; qClear = 1'b0;
    if (clr) qModel = 1'b0; else if (ws) qModel = 1'b1;
    check({tag, " result"}, result, r);
    check({tag, " laneSat R11"}, {28'd0, laneSat}, {28'd0, s});
    check({tag, " outValid R5"}, {31'd0, outValid}, 32'd1);
    check({tag, " qFlag"}, {31'd0, qFlag}, {31'd0, qModel});
  endtask

  task automatic testReset();
    check("R12 outValid", {31'd0, outValid}, 32'd0);
    check("R12 result", result, 32'd0);
    check("R12 laneSat", {28'd0, laneSat}, 32'd0);
    check("R12 qFlag", {31'd0, qFlag}, 32'd0);
  endtask

  task automatic testWord();
    runOp("R1 add plain", 3'b000, 32'd1000, 32'hFFFF_FF00, 1'b0);
    runOp("R1 add pos ovf R7", 3'b000, 32'h7FFF_FFFF, 32'd1, 1'b0);
    runOp("R8 sticky", 3'b000, 32'd5, 32'd6, 1'b0);
    runOp("R2 sub neg ovf", 3'b100, 32'h8000_0000, 32'd1, 1'b0);
    runOp("R1 add neg ovf", 3'b000, 32'h8000_0000, 32'h8000_0000, 1'b0);
  endtask

  task automatic testClear();
    runOp("R10 clear plain", 3'b000, 32'd1, 32'd1, 1'b1);
    runOp("R7 set after clear", 3'b100, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    runOp("R10 clear beats set", 3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
  endtask

  task automatic testHalf();
    runOp("R3 halves sat R9", 3'b001, 32'h7FFF_0001, 32'h0001_0002, 1'b0);
    runOp("R3 halves neg", 3'b001, 32'h8000_7FFF, 32'h8000_7FFF, 1'b0);
    runOp("R2 halves sub", 3'b101, 32'h8000_0005, 32'h0001_0007, 1'b0);
  endtask

  task automatic testByte();
    runOp("R4 bytes no carry", 3'b010, 32'h00FF_7F80, 32'h0001_0180, 1'b0);
    runOp("R4 bytes alt code", 3'b011, 32'h7F7F_0101, 32'h017F_FEFF, 1'b0);
    runOp("R2 bytes sub R9", 3'b110, 32'h8010_7F00, 32'h0120_8101, 1'b0);
  endtask

  task automatic testQPackedAfterSet();
    runOp("R9 set first", 3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    runOp("R9 packed keeps 1", 3'b010, 32'h0000_0001, 32'h0000_0001, 1'b0);
  endtask

  task automatic testHold();
    logic [31:0] prevR; logic [3:0] prevS;
    prevR = result; prevS = laneSat;
    @(negedge clk);
    opA = 32'h1234_5678; opB = 32'h7777_7777; inOp = 3'b010;
    @(posedge clk); #1;
    check("R6 hold result", result, prevR);
    check("R6 hold laneSat", {28'd0, laneSat}, {28'd0, prevS});
    check("R5 idle outValid", {31'd0, outValid}, 32'd0);
  endtask

  initial begin
    #600000;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testWord();
    testClear();
    testHalf();
    testByte();
    testQPackedAfterSet();
    testHold();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule